// File: doc/BRIEF.md
# DRAM Bank Timing Scheduler

This block tracks the command timing of one DRAM bank and sequences its read data burst. A controller presents one request per cycle on a small command port (open a row, read a column, close the bank, or refresh). The block answers combinationally with `cmd_legal`, which says whether that request may be issued in the current cycle. When `cmd_valid` is high and the request is legal, the command is accepted and the bank state and timers move on. All timing is counted in I/O clock cycles.

An accepted read starts two timers at the same moment, and neither depends on the other. The close-after-read timer only covers the time needed to move eight beats from the core into the prefetch buffer. The CAS-latency timer places the data burst. Because of this split, the bank may be closed before its burst has started, and the burst still runs to completion. The burst takes 4 I/O clocks (8 beats on both edges). It is shown on `burst_valid`, and `burst_slot` counts the clock within the burst.

The four timing values are runtime inputs. They are captured by a load strobe and reset to CL=16, tRCD=16, tRP=16 and tRTP=4. A CAS latency below 4 cannot be met, because the prefetch buffer is filled 4 clocks after the read. Such a load is refused and reported.

Top module: `dram_bank_timer`

## Requirements
- R1: After reset the row is closed, `burst_valid` and `cfg_err` are low, and the timing set is CL=16, tRCD=16, tRP=16, tRTP=4.
- R2: Open-row (`cmd_op`=0) is legal only while the row is closed and at least tRP cycles have passed since the last accepted close. Acceptance opens the row from the next cycle.
- R3: Read (`cmd_op`=1) is legal only while the row is open, at least tRCD cycles have passed since the open, and no earlier read is still waiting for or sending its burst.
- R4: Close (`cmd_op`=2) is legal only while the row is open and at least tRTP cycles have passed since the last accepted read. CL and the burst play no part, so a close may be accepted before the burst starts.
- R5: Refresh (`cmd_op`=3) is legal only while the row is closed and tRP has elapsed since the last close. Acceptance changes no state.
- R6: A read accepted in cycle t raises `burst_valid` in cycles t+CL to t+CL+3, with `burst_slot` 0,1,2,3. The burst completes even if the bank is closed earlier.
- R7: A load with `cfg_cl` at or above 4 replaces all four timing values from the next cycle. A load with `cfg_cl` below 4 changes none of them and raises `cfg_err` for exactly the next cycle. Timers already running keep the values they were started with.
- R8: A request that is not legal, or not valid, changes neither the row state nor any timer.
- R9: `cmd_legal` depends only on `cmd_op` and the block state, never on `cmd_valid`. A timing value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Capture the four timing inputs |
| cfg_cl | input | TW | CAS latency in cycles |
| cfg_trcd | input | TW | Open-to-read delay |
| cfg_trp | input | TW | Close-to-open/refresh delay |
| cfg_trtp | input | TW | Read-to-close delay |
| cfg_err | output | 1 | One-cycle pulse after a refused load |
| cmd_valid | input | 1 | Issue the presented request if legal |
| cmd_op | input | 2 | 0 open, 1 read, 2 close, 3 refresh |
| cmd_legal | output | 1 | Presented request is legal this cycle |
| row_open | output | 1 | Bank holds an open row |
| burst_valid | output | 1 | Read burst on the data pins |
| burst_slot | output | 2 | Clock index within the burst |

## Verification
The assertions assume the inputs are stable around the rising edge. They also assume that accepted commands only ever come through `cmd_legal`, so no read can start while a burst is pending. Because the burst sequencer relies on that second assumption, its checks tie acceptance to the busy signal it exports. The stimulus changes every input at the falling edge. It draws opcodes, valid bits and configuration loads from a seeded generator, which includes latencies below 4. Directed sequences cover the reset timing set, a close issued before its burst, and refused requests.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [1:0] {
    OP_ACT  = 2'd0,
    OP_READ = 2'd1,
    OP_PRE  = 2'd2,
    OP_REF  = 2'd3
  } dbt_op_e;

  // clocks from a read until the prefetch buffer holds the data
  localparam int unsigned PF_FILL    = 4;
  // 8 beats, two per clock
  localparam int unsigned BURST_CLKS = 4;
  localparam int unsigned SLOT_W     = $clog2(BURST_CLKS);

  function automatic logic cl_usable(input int unsigned cl);
    return cl >= PF_FILL;
  endfunction
endpackage

// File: rtl/dbt_countdown.sv
module dbt_countdown #(
  parameter int unsigned TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          done
);
  logic [TW-1:0] cnt;

  // value held in the cycle after loading; zero and one both give one cycle
  function automatic logic [TW-1:0] first_count(input logic [TW-1:0] n);
    return (n == '0) ? '0 : n - TW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= first_count(len);
    else if (cnt != '0)    cnt <= cnt - TW'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/dbt_cfg.sv
module dbt_cfg
  import dbt_pkg::*;
#(
  parameter int unsigned TW       = 6,
  parameter int unsigned DEF_CL   = 16,
  parameter int unsigned DEF_TRCD = 16,
  parameter int unsigned DEF_TRP  = 16,
  parameter int unsigned DEF_TRTP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] cl_in,
  input  logic [TW-1:0] trcd_in,
  input  logic [TW-1:0] trp_in,
  input  logic [TW-1:0] trtp_in,
  output logic [TW-1:0] cl,
  output logic [TW-1:0] trcd,
  output logic [TW-1:0] trp,
  output logic [TW-1:0] trtp,
  output logic          err
);
  logic ok_load;
  logic bad_load;

  assign ok_load  = load && cl_usable(int'(cl_in));
  assign bad_load = load && !cl_usable(int'(cl_in));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cl   <= TW'(DEF_CL);
      trcd <= TW'(DEF_TRCD);
      trp  <= TW'(DEF_TRP);
      trtp <= TW'(DEF_TRTP);
      err  <= 1'b0;
    end else begin
      err <= bad_load;
      if (ok_load) begin
        cl   <= cl_in;
        trcd <= trcd_in;
        trp  <= trp_in;
        trtp <= trtp_in;
      end
    end
  end

  // R7
  cfg_cl_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cl >= TW'(PF_FILL));
  // R7
  cfg_hold_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_load |=> err && $stable(cl) && $stable(trcd) && $stable(trp) && $stable(trtp));
endmodule

// File: rtl/dbt_burst.sv
module dbt_burst
  import dbt_pkg::*;
#(
  parameter int unsigned TW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TW-1:0]     cl,
  output logic              busy,
  output logic              valid,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(BURST_CLKS - 1);

  logic          pend;
  logic [TW-1:0] cnt;
  logic          fire;

  // the latency count reaches its last cycle: burst shows next cycle
  assign fire = pend && (cnt == TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      cnt   <= '0;
      valid <= 1'b0;
      slot  <= '0;
    end else begin
      if (start) begin
        pend <= 1'b1;
        cnt  <= cl - TW'(1);
      end else if (fire) begin
        pend <= 1'b0;
      end else if (pend) begin
        cnt <= cnt - TW'(1);
      end

      if (fire) begin
        valid <= 1'b1;
        slot  <= '0;
      end else if (valid) begin
        if (slot == LAST) valid <= 1'b0;
        else              slot  <= slot + SLOT_W'(1);
      end
    end
  end

  assign busy = pend || valid;

  // R3
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R6
  burst_first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> slot == '0);
  // R6
  burst_slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && slot != LAST |=> valid && slot == $past(slot) + SLOT_W'(1));
  // R6
  burst_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && slot == LAST |=> !valid);
endmodule

// File: rtl/dram_bank_timer.sv
module dram_bank_timer
  import dbt_pkg::*;
#(
  parameter int unsigned TW       = 6,
  parameter int unsigned DEF_CL   = 16,
  parameter int unsigned DEF_TRCD = 16,
  parameter int unsigned DEF_TRP  = 16,
  parameter int unsigned DEF_TRTP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [TW-1:0]     cfg_cl,
  input  logic [TW-1:0]     cfg_trcd,
  input  logic [TW-1:0]     cfg_trp,
  input  logic [TW-1:0]     cfg_trtp,
  output logic              cfg_err,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  output logic              cmd_legal,
  output logic              row_open,
  output logic              burst_valid,
  output logic [SLOT_W-1:0] burst_slot
);
  logic [TW-1:0] t_cl, t_rcd, t_rp, t_rtp;
  logic rcd_done, rp_done, rtp_done, rd_busy;
  logic row_q;
  dbt_op_e op;
  logic acc_act, acc_rd, acc_pre, acc_ref;

  dbt_cfg #(.TW(TW), .DEF_CL(DEF_CL), .DEF_TRCD(DEF_TRCD),
            .DEF_TRP(DEF_TRP), .DEF_TRTP(DEF_TRTP)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .cl_in(cfg_cl), .trcd_in(cfg_trcd), .trp_in(cfg_trp), .trtp_in(cfg_trtp),
    .cl(t_cl), .trcd(t_rcd), .trp(t_rp), .trtp(t_rtp), .err(cfg_err));

  assign op = dbt_op_e'(cmd_op);

  always_comb begin
    case (op)
      OP_ACT, OP_REF: cmd_legal = !row_q && rp_done;
      OP_READ:        cmd_legal = row_q && rcd_done && !rd_busy;
      OP_PRE:         cmd_legal = row_q && rtp_done;
      default:        cmd_legal = 1'b0;
    endcase
  end

  assign acc_act = cmd_valid && cmd_legal && (op == OP_ACT);
  assign acc_rd  = cmd_valid && cmd_legal && (op == OP_READ);
  assign acc_pre = cmd_valid && cmd_legal && (op == OP_PRE);
  assign acc_ref = cmd_valid && cmd_legal && (op == OP_REF);

  always_ff @(posedge clk) begin
    if (!rst_n)       row_q <= 1'b0;
    else if (acc_act) row_q <= 1'b1;
    else if (acc_pre) row_q <= 1'b0;
  end
  assign row_open = row_q;

  // open-to-read window
  dbt_countdown #(.TW(TW)) u_rcd (
    .clk(clk), .rst_n(rst_n), .load(acc_act), .len(t_rcd), .done(rcd_done));
  // close recovery window
  dbt_countdown #(.TW(TW)) u_rp (
    .clk(clk), .rst_n(rst_n), .load(acc_pre), .len(t_rp), .done(rp_done));
  // read-to-close window, prefetch fill only
  dbt_countdown #(.TW(TW)) u_rtp (
    .clk(clk), .rst_n(rst_n), .load(acc_rd), .len(t_rtp), .done(rtp_done));

  dbt_burst #(.TW(TW)) u_bst (
    .clk(clk), .rst_n(rst_n), .start(acc_rd), .cl(t_cl),
    .busy(rd_busy), .valid(burst_valid), .slot(burst_slot));

  // R2
  act_opens_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_act |=> row_open);
  // R3
  read_needs_rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |-> row_q && rcd_done);
  // R4
  pre_closes_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pre |=> !row_open);
  // R5
  ref_keeps_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ref |=> !row_open);
  // R8
  reject_keeps_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_legal) |=> row_open == $past(row_open));
endmodule

// File: tb/dram_bank_timer_tb.sv
module dram_bank_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [5:0] cfg_cl = '0, cfg_trcd = '0, cfg_trp = '0, cfg_trtp = '0;
  logic cfg_err;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic cmd_legal, row_open, burst_valid;
  logic [1:0] burst_slot;

  always #4 clk = ~clk;

  dram_bank_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_cl(cfg_cl),
    .cfg_trcd(cfg_trcd), .cfg_trp(cfg_trp), .cfg_trtp(cfg_trtp),
    .cfg_err(cfg_err), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_legal(cmd_legal), .row_open(row_open),
    .burst_valid(burst_valid), .burst_slot(burst_slot));

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;
  // bench model: deadlines in cycle numbers
  int m_cl = 16, m_trcd = 16, m_trp = 16, m_trtp = 4;
  bit m_open = 0, m_err = 0;
  int m_rcd_at = 0, m_rp_at = 0, m_rtp_at = 0, m_free_at = 0, m_bst = -100;
  bit last_legal, last_bv, last_open;

  function automatic int at_least1(int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic bit exp_legal(int op);
    case (op)
      0, 3: return !m_open && cyc >= m_rp_at;
      1:    return m_open && cyc >= m_rcd_at && cyc >= m_free_at;
      default: return m_open && cyc >= m_rtp_at;
    endcase
  endfunction

  function automatic string op_req(int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input bit v, input int op, input bit ld,
                      input int cl, input int rcd, input int rp, input int rtp);
    bit el, ebv;
    @(negedge clk);
    cmd_valid = v; cmd_op = 2'(op); cfg_load = ld;
    cfg_cl = 6'(cl); cfg_trcd = 6'(rcd); cfg_trp = 6'(rp); cfg_trtp = 6'(rtp);
    #1;
    el  = exp_legal(op);
    ebv = (cyc >= m_bst) && (cyc < m_bst + 4);
    chk(cmd_legal == el, op_req(op), int'(cmd_legal), int'(el));
    chk(row_open == m_open, "R8", int'(row_open), int'(m_open));
    chk(burst_valid == ebv, "R6", int'(burst_valid), int'(ebv));
    if (ebv) chk(int'(burst_slot) == cyc - m_bst, "R6", int'(burst_slot), cyc - m_bst);
    chk(cfg_err == m_err, "R7", int'(cfg_err), int'(m_err));
    last_legal = cmd_legal; last_bv = burst_valid; last_open = row_open;
    @(posedge clk);
    if (v && el) begin
      case (op)
        0: begin m_open = 1; m_rcd_at = cyc + at_least1(m_trcd); end
        1: begin
             m_rtp_at = cyc + at_least1(m_trtp);
             m_bst = cyc + m_cl; m_free_at = cyc + m_cl + 4;
           end
        2: begin m_open = 0; m_rp_at = cyc + at_least1(m_trp); end
        default: ;
      endcase
    end
    m_err = ld && (cl < 4);
    if (ld && cl >= 4) begin m_cl = cl; m_trcd = rcd; m_trp = rp; m_trtp = rtp; end
    cyc++;
  endtask

  task automatic idle(input int op);
    step(0, op, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int d;
    bit saw;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(row_open == 0, "R1", int'(row_open), 0);
    chk(burst_valid == 0, "R1", int'(burst_valid), 0);
    chk(cfg_err == 0, "R1", int'(cfg_err), 0);

    // R1 default tRCD=16
    step(1, 0, 0, 0, 0, 0, 0);
    d = 0;
    do begin d++; idle(1); end while (!last_legal && d < 40);
    chk(d == 16, "R1", d, 16);
    // read, then close after tRTP=4, well before the CL=16 burst (R4, R6)
    step(1, 1, 0, 0, 0, 0, 0);
    d = 0;
    do begin d++; idle(2); end while (!last_legal && d < 40);
    chk(d == 4, "R4", d, 4);
    chk(last_bv == 0, "R4", int'(last_bv), 0);
    step(1, 2, 0, 0, 0, 0, 0);
    saw = 0;
    for (int k = 0; k < 20; k++) begin
      idle(0);
      if (last_bv && !last_open) saw = 1;
    end
    chk(saw, "R6", int'(saw), 1);

    // R7 refused load, then a good one
    step(0, 0, 1, 3, 1, 1, 1);
    idle(0);
    chk(last_legal == 1, "R7", int'(last_legal), 1);
    step(0, 0, 1, 5, 2, 3, 2);
    idle(0);

    // R8 rejected open while open, R9 probe without valid
    step(1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    chk(last_legal == 0, "R8", int'(last_legal), 0);
    idle(1);
    chk(last_open == 1, "R8", int'(last_open), 1);
    step(1, 1, 0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0, 0, 0);
    chk(last_legal == 0, "R3", int'(last_legal), 0);
    // R9 zero timings act as one
    step(0, 0, 1, 4, 0, 0, 0);
    for (int k = 0; k < 12; k++) idle(2);

    // seeded random traffic
    for (int n = 0; n < 6000; n++) begin
      bit v, ld;
      int op;
      v  = ($urandom_range(0, 9) < 7);
      op = $urandom_range(0, 3);
      ld = ($urandom_range(0, 99) < 2);
      step(v, op, ld, $urandom_range(2, 9), $urandom_range(0, 6),
           $urandom_range(0, 6), $urandom_range(0, 6));
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule